// File: doc/BRIEF.md
# AHB DMA Burst Type Selector

This block sits between a DMA engine's transfer scheduler and its AHB master port. For each access that the scheduler wants to make, it takes the programmed burst setting, the start byte address and the bytes of data and of free buffer space still outstanding. From these it chooses an HBURST code and a beat count. It then presents the result as an access request and follows the beats of that access until it finishes or is aborted.

A fixed-length incrementing burst is chosen only when the configured length fits on three counts: the remaining data, the remaining space and the span left before the next 1 KB address boundary. When any of these is too short, the access falls back to a single transfer. Buffer-management accesses never use a fixed burst. Once a request has been issued, it is followed to its last beat. Only a bus error response or a receive/transmit disable ends it early. A completion pulse reports how many beats were completed and whether the access was aborted.

The decision input and the access request are valid/ready channels. On the decision channel, `dec_ready` is high only while the block is idle, so no new decision is taken until the previous access has fully finished. On the request channel, the request is held unchanged until `acc_ready` accepts it, or until an abort withdraws it. The beat, error, disable and completion pins are plain control and status signals.

Top module: `ahb_burst_sel`

## Requirements
- R1: The burst setting `cfg_burst` is decoded by its highest set bit: bit 4 selects INCR16, bit 3 INCR8, bit 2 INCR4 and bit 1 INCR. Bit 0 alone, or no bit set, selects SINGLE. The codes on `acc_burst` are SINGLE=000, INCR=001, INCR4=011, INCR8=101 and INCR16=111. A fixed burst has 4, 8 or 16 beats, and each beat is 4 bytes.
- R2: A buffer-management decision (`dec_mgmt`=1) issues SINGLE with 1 beat when the setting selects SINGLE, and INCR with 1 beat for any other setting.
- R3: A data decision whose setting selects a fixed burst of N beats issues that burst, with `acc_beats`=N. This happens only when both `dec_data_left` and `dec_space_left` are at least 4*N bytes and the span fits before the next 1 KB boundary.
- R4: If the data left or the space left is below 4*N bytes, a fixed-burst setting issues SINGLE with 1 beat instead.
- R5: If the address offset within its 1 KB page (`dec_addr[9:0]`) plus 4*N exceeds 1024, SINGLE with 1 beat is issued. A span that ends exactly on the boundary is still issued as the fixed burst.
- R6: After acceptance, the block counts `beat_done` pulses. One cycle after the last beat, `cpl_valid` pulses for one cycle with `cpl_beats` equal to the beat count and `cpl_abort`=0. Without an error or a disable, the access is never ended earlier.
- R7: The request appears one cycle after the decision handshake. It stays valid with a stable code, beat count and address until `acc_ready` is high. `dec_ready` stays low from the decision until the access ends.
- R8: If `bus_err` or `xfer_off` is high while a request is pending or beats are being counted, then in the next cycle `acc_valid` is low and `cpl_valid` pulses with `cpl_abort`=1. `cpl_beats` then gives the beats completed before that cycle. A `beat_done` in the abort cycle is not counted.
- R9: After reset, `acc_valid`=0, `cpl_valid`=0 and `dec_ready`=1.
- R10: A data decision with the INCR setting issues INCR with 1 beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_burst | input | 5 | Programmed burst setting |
| dec_valid | input | 1 | Decision request valid |
| dec_ready | output | 1 | Block idle, decision accepted |
| dec_mgmt | input | 1 | Access is buffer management |
| dec_addr | input | ADDR_W | Start byte address |
| dec_data_left | input | LEN_W | Bytes of data remaining |
| dec_space_left | input | LEN_W | Bytes of free space remaining |
| acc_valid | output | 1 | Access request valid |
| acc_ready | input | 1 | Access request accepted by bus master |
| acc_burst | output | 3 | HBURST code of the request |
| acc_beats | output | 5 | Beat count of the request |
| acc_addr | output | ADDR_W | Start address of the request |
| beat_done | input | 1 | One beat of the current access completed |
| bus_err | input | 1 | AHB error response |
| xfer_off | input | 1 | Receive/transmit disabled |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_beats | output | 5 | Beats completed |
| cpl_abort | output | 1 | Access ended by error or disable |

## Verification
The request is due one cycle after the decision handshake, and the completion pulse one cycle after the last counted beat or after the abort cycle. A withdrawn request is low in that same cycle after the abort. The bench drives every input one nanosecond after a rising edge. A monitor compares results at the falling edge, so each result is read in the cycle in which it is due. Stall and abort checks are read one step after the edge that caused them.

// File: rtl/bst_pkg.sv
package bst_pkg;

  localparam int BST_MAX_BEATS = 16;
  localparam int BST_CNT_W     = $clog2(BST_MAX_BEATS + 1);
  localparam int BST_NUM_FIXED = 3;

  typedef enum logic [2:0] {
    HB_SINGLE = 3'b000,
    HB_INCR   = 3'b001,
    HB_INCR4  = 3'b011,
    HB_INCR8  = 3'b101,
    HB_INCR16 = 3'b111
  } hburst_t;

  typedef enum logic [2:0] {
    SEL_SINGLE,
    SEL_INCR,
    SEL_F4,
    SEL_F8,
    SEL_F16
  } sel_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RUN
  } trk_state_t;

  // beats of fixed burst index i: 4, 8, 16
  function automatic int fixed_beats(input int idx);
    return 4 << idx;
  endfunction

  function automatic hburst_t fixed_code(input int idx);
    case (idx)
      0:       return HB_INCR4;
      1:       return HB_INCR8;
      default: return HB_INCR16;
    endcase
  endfunction

endpackage

// File: rtl/bst_cfg_decode.sv
module bst_cfg_decode
  import bst_pkg::*;
(
  input  logic [4:0] cfg,
  output sel_t       sel
);

  always_comb begin
    if (cfg[4])      sel = SEL_F16;
    else if (cfg[3]) sel = SEL_F8;
    else if (cfg[2]) sel = SEL_F4;
    else if (cfg[1]) sel = SEL_INCR;
    else             sel = SEL_SINGLE;
  end

endmodule

// File: rtl/bst_fit_check.sv
module bst_fit_check
  import bst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 4,
  parameter int PAGE_BYTES = 1024
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LEN_W-1:0]         data_left,
  input  logic [LEN_W-1:0]         space_left,
  output logic [BST_NUM_FIXED-1:0] fits
);

  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [31:0] data32;
  logic [31:0] space32;
  logic [31:0] page_off;

  assign data32   = 32'(data_left);
  assign space32  = 32'(space_left);
  assign page_off = 32'(addr[PAGE_W-1:0]);

  for (genvar gi = 0; gi < BST_NUM_FIXED; gi++) begin : g_fit
    localparam int SPAN = fixed_beats(gi) * BEAT_BYTES;
    logic enough_data;
    logic enough_space;
    logic in_page;
    assign enough_data  = data32 >= 32'(SPAN);
    assign enough_space = space32 >= 32'(SPAN);
    assign in_page      = (page_off + 32'(SPAN)) <= 32'(PAGE_BYTES);
    assign fits[gi]     = enough_data && enough_space && in_page;
  end

endmodule

// File: rtl/bst_chooser.sv
module bst_chooser
  import bst_pkg::*;
(
  input  sel_t                     sel,
  input  logic                     is_mgmt,
  input  logic [BST_NUM_FIXED-1:0] fits,
  output hburst_t                  burst,
  output logic [BST_CNT_W-1:0]     beats
);

  int fix_idx;

  always_comb begin
    case (sel)
      SEL_F4:  fix_idx = 0;
      SEL_F8:  fix_idx = 1;
      SEL_F16: fix_idx = 2;
      default: fix_idx = -1;
    endcase
  end

  always_comb begin
    burst = HB_SINGLE;
    beats = BST_CNT_W'(1);
    if (is_mgmt) begin
      burst = (sel == SEL_SINGLE) ? HB_SINGLE : HB_INCR;
    end else if (fix_idx >= 0) begin
      if (fits[fix_idx]) begin
        burst = fixed_code(fix_idx);
        beats = BST_CNT_W'(fixed_beats(fix_idx));
      end
    end else if (sel == SEL_INCR) begin
      burst = HB_INCR;
    end
  end

endmodule

// File: rtl/bst_beat_tracker.sv
module bst_beat_tracker
  import bst_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BST_CNT_W-1:0] load_beats,
  input  logic                 acc_ready,
  input  logic                 beat_done,
  input  logic                 abort,
  output logic                 idle,
  output logic                 req_on,
  output logic                 cpl_valid,
  output logic [BST_CNT_W-1:0] cpl_beats,
  output logic                 cpl_abort
);

  trk_state_t           state;
  logic [BST_CNT_W-1:0] target;
  logic [BST_CNT_W-1:0] count;
  logic [BST_CNT_W-1:0] count_nxt;

  assign count_nxt = count + 1'b1;
  assign idle      = (state == ST_IDLE);
  assign req_on    = (state == ST_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      target    <= '0;
      count     <= '0;
      cpl_valid <= 1'b0;
      cpl_beats <= '0;
      cpl_abort <= 1'b0;
    end else begin
      cpl_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_REQ;
            target <= load_beats;
            count  <= '0;
          end
        end
        ST_REQ: begin
          if (abort) begin
            state     <= ST_IDLE;
            cpl_valid <= 1'b1;
            cpl_beats <= '0;
            cpl_abort <= 1'b1;
          end else if (acc_ready) begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (abort) begin
            state     <= ST_IDLE;
            cpl_valid <= 1'b1;
            cpl_beats <= count;
            cpl_abort <= 1'b1;
          end else if (beat_done) begin
            if (count_nxt == target) begin
              state     <= ST_IDLE;
              cpl_valid <= 1'b1;
              cpl_beats <= target;
              cpl_abort <= 1'b0;
            end
            count <= count_nxt;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ahb_burst_sel.sv
module ahb_burst_sel
  import bst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 4,
  parameter int PAGE_BYTES = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           cfg_burst,
  input  logic                 dec_valid,
  output logic                 dec_ready,
  input  logic                 dec_mgmt,
  input  logic [ADDR_W-1:0]    dec_addr,
  input  logic [LEN_W-1:0]     dec_data_left,
  input  logic [LEN_W-1:0]     dec_space_left,
  output logic                 acc_valid,
  input  logic                 acc_ready,
  output logic [2:0]           acc_burst,
  output logic [BST_CNT_W-1:0] acc_beats,
  output logic [ADDR_W-1:0]    acc_addr,
  input  logic                 beat_done,
  input  logic                 bus_err,
  input  logic                 xfer_off,
  output logic                 cpl_valid,
  output logic [BST_CNT_W-1:0] cpl_beats,
  output logic                 cpl_abort
);

  sel_t                     sel;
  logic [BST_NUM_FIXED-1:0] fits;
  hburst_t                  pick_burst;
  logic [BST_CNT_W-1:0]     pick_beats;
  logic                     idle;
  logic                     req_on;
  logic                     take;

  bst_cfg_decode u_dec (
    .cfg (cfg_burst),
    .sel (sel)
  );

  bst_fit_check #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .BEAT_BYTES (BEAT_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_fit (
    .addr       (dec_addr),
    .data_left  (dec_data_left),
    .space_left (dec_space_left),
    .fits       (fits)
  );

  bst_chooser u_pick (
    .sel     (sel),
    .is_mgmt (dec_mgmt),
    .fits    (fits),
    .burst   (pick_burst),
    .beats   (pick_beats)
  );

  assign dec_ready = idle;
  assign take      = dec_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_burst <= HB_SINGLE;
      acc_beats <= '0;
      acc_addr  <= '0;
    end else if (take) begin
      acc_burst <= pick_burst;
      acc_beats <= pick_beats;
      acc_addr  <= dec_addr;
    end
  end

  bst_beat_tracker u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take),
    .load_beats (pick_beats),
    .acc_ready  (acc_ready),
    .beat_done  (beat_done),
    .abort      (bus_err || xfer_off),
    .idle       (idle),
    .req_on     (req_on),
    .cpl_valid  (cpl_valid),
    .cpl_beats  (cpl_beats),
    .cpl_abort  (cpl_abort)
  );

  assign acc_valid = req_on;

endmodule

// File: rtl/ahb_burst_sel_chk.sv
module ahb_burst_sel_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 4,
  parameter int PAGE_BYTES = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic              dec_mgmt,
  input logic [LEN_W-1:0]  dec_data_left,
  input logic [LEN_W-1:0]  dec_space_left,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [2:0]        acc_burst,
  input logic [4:0]        acc_beats,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              beat_done,
  input logic              bus_err,
  input logic              xfer_off,
  input logic              cpl_valid,
  input logic              cpl_abort
);

  localparam int PAGE_W = $clog2(PAGE_BYTES);

  p_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (((acc_beats == 5'd4) == (acc_burst == 3'b011)) &&
                   ((acc_beats == 5'd8) == (acc_burst == 3'b101)) &&
                   ((acc_beats == 5'd16) == (acc_burst == 3'b111))));

  p_mgmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_mgmt) |=>
      ((acc_burst == 3'b000 || acc_burst == 3'b001) && acc_beats == 5'd1));

  p_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && !dec_mgmt) |=>
      (acc_beats <= 5'd1 ||
       (32'($past(dec_data_left)) >= 32'(acc_beats) * BEAT_BYTES &&
        32'($past(dec_space_left)) >= 32'(acc_beats) * BEAT_BYTES)));

  p_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (32'(acc_addr[PAGE_W-1:0]) + 32'(acc_beats) * BEAT_BYTES <= PAGE_BYTES));

  p_no_early_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_ready && !acc_valid && !bus_err && !xfer_off && !beat_done) |=>
      (!dec_ready && !cpl_valid));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready && !bus_err && !xfer_off) |=>
      (acc_valid && $stable(acc_burst) && $stable(acc_beats) && $stable(acc_addr)));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_ready && (bus_err || xfer_off)) |=> (!acc_valid && cpl_valid && cpl_abort));

endmodule

bind ahb_burst_sel ahb_burst_sel_chk #(
  .ADDR_W     (ADDR_W),
  .LEN_W      (LEN_W),
  .BEAT_BYTES (BEAT_BYTES),
  .PAGE_BYTES (PAGE_BYTES)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .dec_valid      (dec_valid),
  .dec_ready      (dec_ready),
  .dec_mgmt       (dec_mgmt),
  .dec_data_left  (dec_data_left),
  .dec_space_left (dec_space_left),
  .acc_valid      (acc_valid),
  .acc_ready      (acc_ready),
  .acc_burst      (acc_burst),
  .acc_beats      (acc_beats),
  .acc_addr       (acc_addr),
  .beat_done      (beat_done),
  .bus_err        (bus_err),
  .xfer_off       (xfer_off),
  .cpl_valid      (cpl_valid),
  .cpl_abort      (cpl_abort)
);

// File: tb/ahb_burst_sel_tb_top.sv
module ahb_burst_sel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_burst = '0;
  logic        dec_valid = 1'b0;
  logic        dec_ready;
  logic        dec_mgmt = 1'b0;
  logic [31:0] dec_addr = '0;
  logic [15:0] dec_data_left = '0;
  logic [15:0] dec_space_left = '0;
  logic        acc_valid;
  logic        acc_ready = 1'b0;
  logic [2:0]  acc_burst;
  logic [4:0]  acc_beats;
  logic [31:0] acc_addr;
  logic        beat_done = 1'b0;
  logic        bus_err = 1'b0;
  logic        xfer_off = 1'b0;
  logic        cpl_valid;
  logic [4:0]  cpl_beats;
  logic        cpl_abort;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [39:0] acc_q[$];   // {burst, beats, addr}
  logic [9:0]  acc_tag[$];
  logic [5:0]  cpl_q[$];   // {abort, beats}
  logic [9:0]  cpl_tag[$];

  always #2 clk = ~clk;

  ahb_burst_sel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_mgmt(dec_mgmt),
    .dec_addr(dec_addr), .dec_data_left(dec_data_left), .dec_space_left(dec_space_left),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_burst(acc_burst),
    .acc_beats(acc_beats), .acc_addr(acc_addr), .beat_done(beat_done),
    .bus_err(bus_err), .xfer_off(xfer_off), .cpl_valid(cpl_valid),
    .cpl_beats(cpl_beats), .cpl_abort(cpl_abort)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // expected burst from the requirements
  task automatic predict(input logic [4:0] cfg, input bit mgmt, input logic [31:0] addr,
                         input logic [15:0] dl, input logic [15:0] sl,
                         output logic [2:0] b, output logic [4:0] n);
    int span;
    int want;
    want = cfg[4] ? 16 : cfg[3] ? 8 : cfg[2] ? 4 : 0;
    b = 3'b000;
    n = 5'd1;
    if (mgmt) begin
      b = (cfg[4:1] == 4'b0) ? 3'b000 : 3'b001;
    end else if (want != 0) begin
      span = want * 4;
      if (int'(dl) >= span && int'(sl) >= span && int'(addr[9:0]) + span <= 1024) begin
        n = 5'(want);
        b = (want == 4) ? 3'b011 : (want == 8) ? 3'b101 : 3'b111;
      end
    end else if (cfg[1]) begin
      b = 3'b001;
    end
  endtask

  // abort_at: -1 none, -2 during request, k>=0 after k beats
  task automatic xfer(input string req, input logic [4:0] cfg, input bit mgmt,
                      input logic [31:0] addr, input logic [15:0] dl, input logic [15:0] sl,
                      input int stall, input int abort_at, input bit use_off);
    logic [2:0] b;
    logic [4:0] n;
    int nb;
    predict(cfg, mgmt, addr, dl, sl, b, n);
    if (abort_at != -2) begin
      acc_q.push_back({b, n, addr});
      acc_tag.push_back(10'(0));
    end
    if (abort_at == -1) cpl_q.push_back({1'b0, n});
    else cpl_q.push_back({1'b1, 5'(abort_at < 0 ? 0 : abort_at)});
    cfg_burst = cfg; dec_mgmt = mgmt; dec_addr = addr;
    dec_data_left = dl; dec_space_left = sl;
    dec_valid = 1'b1;
    acc_ready = (stall == 0 && abort_at != -2);
    step();
    dec_valid = 1'b0;
    check(acc_valid === 1'b1, {req, " R7 request due"}, 64'(acc_valid), 64'd1);
    if (abort_at == -2) begin
      if (use_off) xfer_off = 1'b1; else bus_err = 1'b1;
      step();
      bus_err = 1'b0; xfer_off = 1'b0;
      check(acc_valid === 1'b0, {req, " R8 request dropped"}, 64'(acc_valid), 64'd0);
    end else begin
      for (int k = 0; k < stall; k++) begin
        check(acc_valid === 1'b1 && acc_burst === b && acc_beats === n,
              {req, " R7 held while stalled"}, 64'({acc_valid, acc_burst, acc_beats}),
              64'({1'b1, b, n}));
        step();
      end
      acc_ready = 1'b1;
      step();
      acc_ready = 1'b0;
      check(dec_ready === 1'b0, {req, " R7 busy until done"}, 64'(dec_ready), 64'd0);
      nb = (abort_at >= 0) ? abort_at : int'(n);
      for (int k = 0; k < nb; k++) begin
        beat_done = 1'b1;
        step();
      end
      beat_done = 1'b0;
      if (abort_at >= 0) begin
        if (use_off) xfer_off = 1'b1; else bus_err = 1'b1;
        beat_done = 1'b1;
        step();
        bus_err = 1'b0; xfer_off = 1'b0; beat_done = 1'b0;
        check(acc_valid === 1'b0 && dec_ready === 1'b1, {req, " R8 ended at once"},
              64'({acc_valid, dec_ready}), 64'b01);
      end
    end
    step();
    step();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (acc_valid && acc_ready) begin
        if (acc_q.size() == 0) check(1'b0, "R7 unexpected request", 64'(acc_burst), 64'd0);
        else begin
          logic [39:0] e;
          e = acc_q.pop_front();
          void'(acc_tag.pop_front());
          check({acc_burst, acc_beats, acc_addr} === e, "R1 R3 R4 R5 request content",
                64'({acc_burst, acc_beats, acc_addr}), 64'(e));
        end
      end
      if (cpl_valid) begin
        if (cpl_q.size() == 0) check(1'b0, "R6 unexpected completion", 64'(cpl_beats), 64'd0);
        else begin
          logic [5:0] e;
          e = cpl_q.pop_front();
          check({cpl_abort, cpl_beats} === e, "R6 R8 completion",
                64'({cpl_abort, cpl_beats}), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check(acc_valid === 1'b0 && cpl_valid === 1'b0 && dec_ready === 1'b1, "R9 reset state",
          64'({acc_valid, cpl_valid, dec_ready}), 64'b001);
    rst_n = 1'b1;
    step();
    check(acc_valid === 1'b0 && dec_ready === 1'b1, "R9 after reset release",
          64'({acc_valid, dec_ready}), 64'b01);

    xfer("R3 incr16",           5'b10000, 0, 32'h0000_0100, 16'd200, 16'd200, 0, -1, 0);
    xfer("R3 incr8",            5'b01000, 0, 32'h0000_0200, 16'd32,  16'd40,  0, -1, 0);
    xfer("R3 incr4",            5'b00100, 0, 32'h0000_0010, 16'd16,  16'd16,  0, -1, 0);
    xfer("R1 priority",         5'b11111, 0, 32'h0000_0000, 16'd64,  16'd64,  0, -1, 0);
    xfer("R1 incr8 over incr4", 5'b01110, 0, 32'h0000_0040, 16'd100, 16'd100, 0, -1, 0);
    xfer("R4 short data",       5'b10000, 0, 32'h0000_0000, 16'd60,  16'd500, 0, -1, 0);
    xfer("R4 short space",      5'b01000, 0, 32'h0000_0000, 16'd500, 16'd28,  0, -1, 0);
    xfer("R5 crosses page",     5'b10000, 0, 32'h0000_03C4, 16'd500, 16'd500, 0, -1, 0);
    xfer("R5 ends on page",     5'b10000, 0, 32'h0000_07C0, 16'd500, 16'd500, 0, -1, 0);
    xfer("R5 incr4 crosses",    5'b00100, 0, 32'h0000_0BF4, 16'd500, 16'd500, 0, -1, 0);
    xfer("R2 mgmt incr",        5'b10000, 1, 32'h0000_0100, 16'd500, 16'd500, 0, -1, 0);
    xfer("R2 mgmt single",      5'b00001, 1, 32'h0000_0100, 16'd500, 16'd500, 0, -1, 0);
    xfer("R10 data incr",       5'b00010, 0, 32'h0000_0300, 16'd500, 16'd500, 0, -1, 0);
    xfer("R1 none set single",  5'b00000, 0, 32'h0000_0300, 16'd500, 16'd500, 0, -1, 0);
    xfer("R7 stall",            5'b01000, 0, 32'h0000_0400, 16'd64,  16'd64,  3, -1, 0);
    xfer("R8 error mid burst",  5'b01000, 0, 32'h0000_0500, 16'd64,  16'd64,  0, 3,  0);
    xfer("R8 disable mid",      5'b10000, 0, 32'h0000_0600, 16'd64,  16'd64,  1, 10, 1);
    xfer("R8 disable in req",   5'b00100, 0, 32'h0000_0700, 16'd64,  16'd64,  0, -2, 1);
    xfer("R8 error in req",     5'b10000, 0, 32'h0000_0800, 16'd64,  16'd64,  0, -2, 0);
    xfer("R6 after abort",      5'b00100, 0, 32'h0000_0900, 16'd64,  16'd64,  0, -1, 0);

    check(acc_q.size() == 0 && cpl_q.size() == 0, "R6 all results seen",
          64'(acc_q.size() + cpl_q.size()), 64'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule